// File: doc/BRIEF.md
# Single-Transition Row Position Encoder

This block reduces one row of time-ordered samples to a short code. Each row holds `ROW_W` samples of one input line. Bit 0 is the earliest sample. The input's rising edges are at least one row period apart, so a row is expected to hold at most one place where a 0 sample is followed by a 1 sample. The encoder finds that place and reports its index. It also reports the level of the earliest sample, so that a rising edge which falls exactly on a row boundary can still be recovered from two consecutive codes.

The encoding logic is combinational. The code and its valid flag are registered, so the block can sit as the second stage of a readout pipeline: a row presented with its strobe in one cycle appears as a code in the next. When a row holds more than one rising pair, the lowest index wins, so the code never depends on how the OR-encoding merges several hot lines.

Top module: `enc_row_code`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after its release, code_valid_o is 0 and code_o is all zeros.
- R2: code_valid_o equals the value row_valid_i had at the previous rising clock edge, so the latency is one clock.
- R3: For an accepted row, bit IDX_W of code_o (the MSB, bit 5 by default) equals row bit 0.
- R4: If an accepted row has exactly one index k in 1..ROW_W-1 with bit k-1 = 0 and bit k = 1, then bits IDX_W-1:0 of code_o equal k.
- R5: An all-zeros row encodes as all zeros (000000 by default).
- R6: An all-ones row encodes with the MSB 1 and the position field 0 (100000 by default).
- R7: A row with no 0-then-1 pair has a position field of 0. An example is a block of ones at the bottom with zeros above it.
- R8: If a row has several 0-then-1 pairs, the position field is the smallest such index k.
- R9: While row_valid_i is low, code_o keeps the last accepted code. The row_bits_i input has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| row_valid_i | input | 1 | Strobe; the row on row_bits_i is accepted this cycle |
| row_bits_i | input | ROW_W | Sampled row; bit 0 is the earliest sample |
| code_valid_o | output | 1 | The code was updated by a row accepted in the previous cycle |
| code_o | output | IDX_W+1 | {row bit 0, index of the first 0-then-1 pair} |

## Verification
The bench builds the block with its default ROW_W of 32. This gives a 5-bit position field and a 6-bit code, and every transition index from 1 to 31 can be swept in a few hundred cycles. The sweep covers each index with bit 0 clear and with bit 0 set. At index 1 with bit 0 set, the row becomes all ones and must fall back to position 0. Directed rows cover multiple pairs, rows with no rising pair, holding the code while the strobe is low, and a reset asserted partway through the run.

// File: rtl/enc_row_pkg.sv
package enc_row_pkg;
  parameter int unsigned ENC_ROW_W_DEF = 32;

  // Number of bits needed to index a row of n samples.
  function automatic int unsigned idx_bits(input int unsigned n);
    return $clog2(n);
  endfunction
endpackage

// File: rtl/enc_rise_scan.sv
// Marks every index k where sample k-1 is low and sample k is high.
module enc_rise_scan #(
  parameter int unsigned ROW_W = 32
) (
  input  logic [ROW_W-1:0] row_i,
  output logic [ROW_W-1:0] rise_o
);
  assign rise_o[0] = 1'b0;

  for (genvar g = 1; g < ROW_W; g++) begin : g_pair
    assign rise_o[g] = row_i[g] & ~row_i[g-1];
  end
endmodule

// File: rtl/enc_first_keep.sv
// Keeps only the lowest set line of the rise mask.
module enc_first_keep #(
  parameter int unsigned ROW_W = 32
) (
  input  logic [ROW_W-1:0] mask_i,
  output logic [ROW_W-1:0] first_o
);
  function automatic logic [ROW_W-1:0] keep_lowest(input logic [ROW_W-1:0] m);
    return m & (~m + 1'b1);
  endfunction

  assign first_o = keep_lowest(mask_i);
endmodule

// File: rtl/enc_onehot_or.sv
// OR-encodes a one-hot (or all-zero) vector into an index.
module enc_onehot_or #(
  parameter int unsigned ROW_W = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [ROW_W-1:0] hot_i,
  output logic [IDX_W-1:0] idx_o
);
  function automatic logic [IDX_W-1:0] or_encode(input logic [ROW_W-1:0] h);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int unsigned k = 0; k < ROW_W; k++) begin
      if (h[k]) acc = acc | IDX_W'(k);
    end
    return acc;
  endfunction

  assign idx_o = or_encode(hot_i);
endmodule

// File: rtl/enc_row_code.sv
module enc_row_code
  import enc_row_pkg::*;
#(
  parameter int unsigned ROW_W = ENC_ROW_W_DEF,
  localparam int unsigned IDX_W = idx_bits(ROW_W),
  localparam int unsigned CODE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_valid_i,
  input  logic [ROW_W-1:0]  row_bits_i,
  output logic              code_valid_o,
  output logic [CODE_W-1:0] code_o
);
  // Named internal events, used by the bound checker.
  logic [ROW_W-1:0] rise_w;
  logic [ROW_W-1:0] pick_w;
  logic [IDX_W-1:0] pos_w;

  enc_rise_scan #(.ROW_W(ROW_W)) u_scan (
    .row_i  (row_bits_i),
    .rise_o (rise_w)
  );

  enc_first_keep #(.ROW_W(ROW_W)) u_keep (
    .mask_i  (rise_w),
    .first_o (pick_w)
  );

  enc_onehot_or #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_or (
    .hot_i (pick_w),
    .idx_o (pos_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_valid_o <= 1'b0;
      code_o       <= '0;
    end else begin
      code_valid_o <= row_valid_i;
      if (row_valid_i) code_o <= {row_bits_i[0], pos_w};
    end
  end
endmodule

// File: rtl/enc_row_code_chk.sv
module enc_row_code_chk #(
  parameter int unsigned ROW_W = 32,
  localparam int unsigned IDX_W = $clog2(ROW_W),
  localparam int unsigned CODE_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_valid_i,
  input logic [ROW_W-1:0]  row_bits_i,
  input logic              code_valid_o,
  input logic [CODE_W-1:0] code_o,
  input logic [ROW_W-1:0]  rise_w,
  input logic [ROW_W-1:0]  pick_w
);
  // Checker's own copy of the last accepted row.
  logic [ROW_W-1:0] row_seen;
  logic [IDX_W-1:0] pos_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) row_seen <= '0;
    else if (row_valid_i) row_seen <= row_bits_i;
  end

  assign pos_seen = code_o[IDX_W-1:0];

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid_i |=> code_valid_o);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid_i |=> !code_valid_o);

  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> (code_o[CODE_W-1] == row_seen[0]));

  p_pos_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_seen != '0) |-> (row_seen[pos_seen] && !row_seen[pos_seen - 1'b1]));

  p_zero_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid_i && row_bits_i == '0) |=> (code_o == '0));

  p_single_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_w) && ((rise_w != '0) == (pick_w != '0)));

  p_hold_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid_i |=> $stable(code_o));
endmodule

bind enc_row_code enc_row_code_chk #(.ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .row_valid_i  (row_valid_i),
  .row_bits_i   (row_bits_i),
  .code_valid_o (code_valid_o),
  .code_o       (code_o),
  .rise_w       (rise_w),
  .pick_w       (pick_w)
);

// File: tb/enc_row_code_test.sv
module enc_row_code_test;
  localparam int unsigned W = 32;

  typedef struct packed {
    logic [31:0] row;
    logic [5:0]  code;
    logic [3:0]  req;
  } vec_t;

  // Directed table: row, expected code, requirement number.
  localparam vec_t TBL [11] = '{
    '{32'h0000_0000, 6'h00, 4'd5},  // R5 all zeros
    '{32'hFFFF_FFFF, 6'h20, 4'd6},  // R6 all ones
    '{32'h0000_FFFF, 6'h20, 4'd7},  // R7 no rising pair
    '{32'h8000_0000, 6'd31, 4'd4},  // R4 top index
    '{32'h0000_0002, 6'd1,  4'd4},  // R4 short pulse at 1
    '{32'hFFFF_FFFE, 6'd1,  4'd4},  // R4 index 1
    '{32'h0000_FF01, 6'd40, 4'd3},  // R3 bit0 set, pair at 8
    '{32'hF0F0_0000, 6'd20, 4'd8},  // R8 two pairs
    '{32'h0001_0101, 6'd40, 4'd8},  // R8 bit0 set, several pairs
    '{32'h5555_5555, 6'd34, 4'd8},  // R8 alternating
    '{32'hAAAA_AAAA, 6'd1,  4'd8}   // R8 alternating, inverted
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         row_valid_i = 1'b0;
  logic [W-1:0] row_bits_i = '0;
  logic         code_valid_o;
  logic [5:0]   code_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  enc_row_code uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_valid_i  (row_valid_i),
    .row_bits_i   (row_bits_i),
    .code_valid_o (code_valid_o),
    .code_o       (code_o)
  );

  function automatic string rname(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  9: return "R9";
      default: return "R?";
    endcase
  endfunction

  // Reference: scan downward so the last hit kept is the lowest pair.
  function automatic logic [5:0] ref_code(input logic [W-1:0] r);
    logic [4:0] p;
    p = '0;
    for (int k = W - 1; k >= 1; k--) begin
      if (r[k] == 1'b1 && r[k-1] == 1'b0) p = 5'(k);
    end
    return {r[0], p};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a row for one cycle; check at the following falling edge.
  task automatic push(input logic [W-1:0] r, input logic [5:0] exp, input string req);
    @(negedge clk);
    row_bits_i  = r;
    row_valid_i = 1'b1;
    @(negedge clk);
    row_valid_i = 1'b0;
    check("R2", {7'd0, code_valid_o}, 8'd1);
    check(req, {2'd0, code_o}, {2'd0, exp});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {7'd0, code_valid_o}, 8'd0);
    check("R1", {2'd0, code_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {7'd0, code_valid_o}, 8'd0);
    check("R1", {2'd0, code_o}, 8'd0);

    // Directed table
    for (int i = 0; i < 11; i++) begin
      push(TBL[i].row, TBL[i].code, rname(int'(TBL[i].req)));
      check(rname(int'(TBL[i].req)), {2'd0, ref_code(TBL[i].row)}, {2'd0, TBL[i].code});
    end

    // Sweep every transition index, with bit 0 clear (R4) and set (R3)
    for (int k = 1; k < W; k++) begin
      logic [W-1:0] r;
      r = ~((W'(1) << k) - 1);
      push(r, ref_code(r), "R4");
      check("R4", {2'd0, code_o}, {3'd0, 5'(k)});
      r[0] = 1'b1;
      push(r, ref_code(r), "R3");
      check("R3", {7'd0, code_o[5]}, 8'd1);
    end

    // R9: code holds while the strobe is low and the row changes
    push(32'h0000_0400, 6'd10, "R4");
    @(negedge clk);
    row_bits_i = 32'hFFFF_0001;
    @(negedge clk);
    check("R9", {2'd0, code_o}, 8'd10);
    check("R2", {7'd0, code_valid_o}, 8'd0);
    row_bits_i = 32'h0000_0000;
    @(negedge clk);
    check("R9", {2'd0, code_o}, 8'd10);

    // R1: reset asserted partway through
    push(32'hFFFF_FF81, 6'd39, "R8");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {2'd0, code_o}, 8'd0);
    check("R1", {7'd0, code_valid_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {2'd0, code_o}, 8'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule